// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This controller decides when a battery-free nonvolatile memory copies its whole SRAM array into the nonvolatile cells (a store) or copies the cells back into the SRAM (a recall). Three sources can ask for a store:

- an active-low request line that is shared with the busy indication, driven by the block through an open-drain pull;
- a software store pulse;
- a supply-low comparator flag.

A recall pulse asks for the reverse copy. A pulse for each completed SRAM write marks the array as modified. Hardware and supply-low stores are skipped when nothing has been written since the last transfer. Software stores always run.

The block gates the SRAM read and write enables while a transfer is pending or running. It starts the array copy with a one-cycle start pulse and a direction bit, and waits for a done pulse from the array. After a store, the SRAM stays locked until the shared line is seen high again. A saturating count of completed stores raises a wear warning at a parameterised limit, which defaults to 200000.

Top module: `nv_xfer_seq`

## Requirements
- R1: A modified flag is set by `wr_done_i` and cleared on the edge that starts any store or recall. A hardware or supply-low store found with the flag clear is skipped: no start pulse, `line_pull_o` stays low, and the block stays idle.
- R2: A software store pulse in idle starts a store on the next edge whether or not the modified flag is set.
- R3: When idle, the block samples `line_n_i` high on one edge and low on the next. It then waits, and its start pulse appears `delay_cycles_i` cycles after that edge, with a value of 0 treated as 1. The store runs only if the modified flag is set at the end of the wait.
- R4: During that wait, `rd_en_o` follows `rd_req_i`. A write that was enabled in the previous cycle keeps `wr_en_o` high while `wr_req_i` stays high.
- R5: While `line_n_i` is low, a write that was not enabled in the previous cycle gets no `wr_en_o`. In idle the enable returns as soon as the line is high.
- R6: `line_pull_o` is high (pulling the line low) from the first store cycle up to the edge that samples `xfer_done_i`.
- R7: After a store completes, `rd_en_o` and `wr_en_o` stay low until an edge samples `line_n_i` high. From the following cycle they follow their requests again.
- R8: A rising edge of `pwr_low_i` in idle starts a store on the next edge, provided the modified flag is set.
- R9: `xfer_start_o` is a one-cycle pulse. `xfer_dir_o` is 1 for a store and 0 for a recall. During any transfer `rd_en_o` and `wr_en_o` are low.
- R10: Requests sampled on the same idle edge are served in this priority: supply-low first, then hardware, then software store, then recall. The losing requests of that edge are dropped.
- R11: A recall returns to idle on the edge that samples `xfer_done_i`, with the modified flag clear and without raising `line_pull_o`.
- R12: `wear_warn_o` rises once the count of completed stores reaches `WEAR_LIMIT`. The count saturates there and the warning stays high.
- R13: After reset, `line_pull_o`, `xfer_start_o` and `wear_warn_o` are low, the modified flag is clear, and reads and writes are enabled on request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| delay_cycles_i | input | DLY_W | Grace window length in cycles for hardware stores |
| line_n_i | input | 1 | Level of the shared active-low request/busy line |
| line_pull_o | output | 1 | 1 pulls the shared line low (busy) |
| sw_store_i | input | 1 | Software store request pulse |
| pwr_low_i | input | 1 | Supply-low comparator flag |
| recall_i | input | 1 | Recall request pulse |
| wr_done_i | input | 1 | Pulse per completed SRAM write |
| rd_req_i | input | 1 | SRAM read request |
| wr_req_i | input | 1 | SRAM write request |
| rd_en_o | output | 1 | Gated SRAM read enable |
| wr_en_o | output | 1 | Gated SRAM write enable |
| xfer_start_o | output | 1 | One-cycle array transfer start |
| xfer_dir_o | output | 1 | 1 store, 0 recall |
| xfer_done_i | input | 1 | Array transfer complete pulse |
| wear_warn_o | output | 1 | Store count has reached WEAR_LIMIT |

## Verification
The read and write enables are combinational from the requests, the line level and the registered state, so their values are due in the same cycle as the stimulus. The start pulse is due one edge after a software, supply-low or recall request, and `delay_cycles_i` edges after the edge that first samples the line low. The release from the post-store lock is due on the edge after the line is seen high. The bench drives inputs just after the falling clock edge and samples there after a short settle. It waits for the array stub's done pulse on a rising edge and then checks on the next falling edge, counting exactly the edges named above.

// File: rtl/nv_xfer_pkg.sv
`timescale 1ns/1ps
package nv_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DELAY   = 3'd1,
    ST_STORE   = 3'd2,
    ST_RECALL  = 3'd3,
    ST_RELEASE = 3'd4
  } seq_state_t;

  // grace window is over once the elapsed count reaches the limit (0 acts as 1)
  function automatic logic dly_expired(input logic [31:0] elapsed, input logic [31:0] lim);
    return (elapsed >= lim);
  endfunction

  // saturating increment of the completed-store count
  function automatic logic [31:0] wear_next(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt >= lim) ? cnt : cnt + 32'd1;
  endfunction

endpackage

// File: rtl/nv_dirty_trk.sv
`timescale 1ns/1ps
module nv_dirty_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);

  logic dirty_q;

  // clear wins: a write finishing on the start edge is inside the copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dirty_q <= 1'b0;
    else if (clr_i) dirty_q <= 1'b0;
    else if (set_i) dirty_q <= 1'b1;
  end

  assign dirty_o = dirty_q;

  // R1
  dirty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !dirty_o);

endmodule

// File: rtl/nv_wear_cnt.sv
`timescale 1ns/1ps
module nv_wear_cnt #(
  parameter int unsigned WEAR_LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  output logic warn_o
);

  localparam int unsigned CNT_W = $clog2(WEAR_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= CNT_W'(nv_xfer_pkg::wear_next(32'(cnt_q), 32'(WEAR_LIMIT)));
  end

  assign warn_o = (32'(cnt_q) >= WEAR_LIMIT);

  // R12
  wear_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_o |=> warn_o);

  // R12
  wear_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_o && inc_i) |=> $stable(cnt_q));

endmodule

// File: rtl/nv_seq_fsm.sv
`timescale 1ns/1ps
module nv_seq_fsm
  import nv_xfer_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] delay_cycles_i,
  input  logic             line_n_i,
  input  logic             sw_store_i,
  input  logic             pwr_low_i,
  input  logic             recall_i,
  input  logic             dirty_i,
  input  logic             rd_req_i,
  input  logic             wr_req_i,
  input  logic             xfer_done_i,
  output logic             busy_o,
  output logic             rd_en_o,
  output logic             wr_en_o,
  output logic             xfer_start_o,
  output logic             xfer_dir_o,
  output logic             xfer_go_o,
  output logic             store_done_o
);

  seq_state_t       st_q, st_d;
  logic [DLY_W-1:0] dly_q;
  logic             line_q, pwr_q, wr_act_q, start_q, dir_q;
  logic             hw_fall, pwr_rise, expired, go_store, go_rcl, sram_open;

  assign hw_fall  = line_q & ~line_n_i;
  assign pwr_rise = pwr_low_i & ~pwr_q;
  assign expired  = dly_expired(32'(dly_q), 32'(delay_cycles_i));

  always_comb begin
    st_d     = st_q;
    go_store = 1'b0;
    go_rcl   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pwr_rise)        go_store = dirty_i;
        else if (hw_fall)    st_d     = ST_DELAY;
        else if (sw_store_i) go_store = 1'b1;
        else if (recall_i)   go_rcl   = 1'b1;
      end
      ST_DELAY: begin
        if (expired) begin
          if (dirty_i) go_store = 1'b1;
          else         st_d     = ST_IDLE;
        end
      end
      ST_STORE:   if (xfer_done_i) st_d = ST_RELEASE;
      ST_RECALL:  if (xfer_done_i) st_d = ST_IDLE;
      ST_RELEASE: if (line_n_i)    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
    if (go_store) st_d = ST_STORE;
    if (go_rcl)   st_d = ST_RECALL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      dly_q    <= '0;
      line_q   <= 1'b1;
      pwr_q    <= 1'b0;
      wr_act_q <= 1'b0;
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      line_q   <= line_n_i;
      pwr_q    <= pwr_low_i;
      wr_act_q <= wr_en_o;
      start_q  <= go_store | go_rcl;
      if (go_store)    dir_q <= 1'b1;
      else if (go_rcl) dir_q <= 1'b0;
      if (st_q != ST_DELAY) dly_q <= DLY_W'(1);
      else if (!expired)    dly_q <= dly_q + DLY_W'(1);
    end
  end

  assign sram_open    = (st_q == ST_IDLE) || (st_q == ST_DELAY);
  assign busy_o       = (st_q == ST_STORE);
  assign rd_en_o      = rd_req_i & sram_open;
  assign wr_en_o      = wr_req_i & sram_open & (line_n_i | wr_act_q);
  assign xfer_start_o = start_q;
  assign xfer_dir_o   = dir_q;
  assign xfer_go_o    = go_store | go_rcl;
  assign store_done_o = busy_o & xfer_done_i;

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_o |=> !xfer_start_o);

  // R9
  xfer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECALL || busy_o) |-> (!rd_en_o && !wr_en_o));

  // R5
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en_o) |-> line_n_i);

  // R7
  post_store_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (!rd_en_o && !wr_en_o));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !xfer_done_i) |=> busy_o);

endmodule

// File: rtl/nv_xfer_seq.sv
`timescale 1ns/1ps
module nv_xfer_seq #(
  parameter int unsigned DLY_W      = 8,
  parameter int unsigned WEAR_LIMIT = 200000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] delay_cycles_i,
  input  logic             line_n_i,
  output logic             line_pull_o,
  input  logic             sw_store_i,
  input  logic             pwr_low_i,
  input  logic             recall_i,
  input  logic             wr_done_i,
  input  logic             rd_req_i,
  input  logic             wr_req_i,
  output logic             rd_en_o,
  output logic             wr_en_o,
  output logic             xfer_start_o,
  output logic             xfer_dir_o,
  input  logic             xfer_done_i,
  output logic             wear_warn_o
);

  logic dirty;
  logic xfer_go;
  logic store_done;

  nv_dirty_trk u_dirty (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (wr_done_i),
    .clr_i   (xfer_go),
    .dirty_o (dirty)
  );

  nv_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .delay_cycles_i (delay_cycles_i),
    .line_n_i       (line_n_i),
    .sw_store_i     (sw_store_i),
    .pwr_low_i      (pwr_low_i),
    .recall_i       (recall_i),
    .dirty_i        (dirty),
    .rd_req_i       (rd_req_i),
    .wr_req_i       (wr_req_i),
    .xfer_done_i    (xfer_done_i),
    .busy_o         (line_pull_o),
    .rd_en_o        (rd_en_o),
    .wr_en_o        (wr_en_o),
    .xfer_start_o   (xfer_start_o),
    .xfer_dir_o     (xfer_dir_o),
    .xfer_go_o      (xfer_go),
    .store_done_o   (store_done)
  );

  nv_wear_cnt #(.WEAR_LIMIT(WEAR_LIMIT)) u_wear (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (store_done),
    .warn_o (wear_warn_o)
  );

  // R1
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start_o && xfer_dir_o) |-> line_pull_o);

endmodule

// File: tb/test_nv_xfer_seq.sv
`timescale 1ns/1ps
module test_nv_xfer_seq;

  localparam int DLY = 4;
  localparam int LAT = 3;
  localparam int LIM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] delay_cycles = 8'(DLY);
  logic ext_pull = 1'b0, sw = 1'b0, pwr = 1'b0, rcl = 1'b0, wr_done = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0, xfer_done = 1'b0;
  logic line_n, line_pull, rd_en, wr_en, xfer_start, xfer_dir, wear_warn;
  int n_chk = 0, n_fail = 0, n_store = 0, lat = 0;

  always #10 clk = ~clk;

  assign line_n = ~(ext_pull | line_pull);

  nv_xfer_seq #(.DLY_W(8), .WEAR_LIMIT(LIM)) i_nv_xfer_seq (
    .clk(clk), .rst_n(rst_n), .delay_cycles_i(delay_cycles),
    .line_n_i(line_n), .line_pull_o(line_pull),
    .sw_store_i(sw), .pwr_low_i(pwr), .recall_i(rcl), .wr_done_i(wr_done),
    .rd_req_i(rd_req), .wr_req_i(wr_req), .rd_en_o(rd_en), .wr_en_o(wr_en),
    .xfer_start_o(xfer_start), .xfer_dir_o(xfer_dir), .xfer_done_i(xfer_done),
    .wear_warn_o(wear_warn)
  );

  // array stub with fixed done latency
  always @(negedge clk) begin
    xfer_done = 1'b0;
    if (lat == 1) begin
      xfer_done = 1'b1;
      if (xfer_dir) n_store++;
    end
    if (lat != 0) lat--;
    if (xfer_start) lat = LAT;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_done();
    int g = 0;
    do begin
      @(posedge clk);
      g++;
    end while (!xfer_done && g < 50);
    if (g >= 50) chk("done_timeout", 0, 1);
    tick();
  endtask

  task automatic pulse_write_done();
    wr_done = 1'b1; tick(); wr_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 pull", line_pull, 0);
    chk("R13 start", xfer_start, 0);
    chk("R13 warn", wear_warn, 0);
    rd_req = 1'b1; wr_req = 1'b1; #1;
    chk("R13 rd_en", rd_en, 1);
    chk("R13 wr_en", wr_en, 1);
    rd_req = 1'b0; wr_req = 1'b0; tick();
  endtask

  // hardware request with the modified flag clear
  task automatic t_hw_skip(string tag);
    logic seen = 1'b0;
    ext_pull = 1'b1; wr_req = 1'b1; rd_req = 1'b1; #1;
    chk({tag, " R5 new write blocked"}, wr_en, 0);
    for (int k = 0; k < DLY + 4; k++) begin
      tick();
      if (xfer_start || line_pull) seen = 1'b1;
    end
    chk({tag, " R1 skipped store"}, seen, 0);
    chk({tag, " R5 still blocked"}, wr_en, 0);
    chk({tag, " R4 reads idle"}, rd_en, 1);
    ext_pull = 1'b0; #1;
    chk({tag, " R5 write after release"}, wr_en, 1);
    wr_req = 1'b0; rd_req = 1'b0; tick();
  endtask

  task automatic t_hw_store();
    pulse_write_done();
    wr_req = 1'b1; tick();
    ext_pull = 1'b1;
    tick();
    chk("R4 write in progress kept", wr_en, 1);
    rd_req = 1'b1; #1;
    chk("R4 read in window", rd_en, 1);
    wr_req = 1'b0;
    tick();
    wr_req = 1'b1; #1;
    chk("R5 new write in window", wr_en, 0);
    wr_req = 1'b0;
    for (int k = 3; k <= DLY; k++) begin
      tick();
      chk("R3 no start inside window", xfer_start, 0);
    end
    tick();
    chk("R3 start after window", xfer_start, 1);
    chk("R9 dir store", xfer_dir, 1);
    chk("R6 busy", line_pull, 1);
    chk("R9 read gated", rd_en, 0);
    tick();
    chk("R9 start one cycle", xfer_start, 0);
    chk("R6 busy held", line_pull, 1);
    wait_done();
    chk("R6 busy released", line_pull, 0);
    chk("R7 locked", rd_en, 0);
    tick();
    chk("R7 still locked", rd_en, 0);
    chk("R12 warn below", wear_warn, (n_store >= LIM));
    ext_pull = 1'b0;
    tick();
    chk("R7 unlocked", rd_en, 1);
    rd_req = 1'b0; tick();
  endtask

  task automatic t_sw_store();
    rd_req = 1'b1;
    sw = 1'b1; tick(); sw = 1'b0;
    chk("R2 start clean", xfer_start, 1);
    chk("R2 dir", xfer_dir, 1);
    chk("R6 busy sw", line_pull, 1);
    wait_done();
    chk("R7 lock one cycle", rd_en, 0);
    tick();
    chk("R7 line high unlock", rd_en, 1);
    rd_req = 1'b0; tick();
  endtask

  task automatic t_pwr();
    logic seen = 1'b0;
    pwr = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      if (xfer_start || line_pull) seen = 1'b1;
    end
    chk("R1 pwr skipped clean", seen, 0);
    pwr = 1'b0; tick();
    pulse_write_done();
    // all requests together: supply-low wins and starts at once
    pwr = 1'b1; ext_pull = 1'b1; sw = 1'b1; rcl = 1'b1;
    tick();
    sw = 1'b0; rcl = 1'b0;
    chk("R8 R10 pwr immediate", xfer_start, 1);
    chk("R10 dir store", xfer_dir, 1);
    wait_done();
    chk("R12 warn at limit", wear_warn, (n_store >= LIM));
    chk("R12 warn expected", wear_warn, 1);
    ext_pull = 1'b0; pwr = 1'b0; tick(); tick();
    chk("R10 dropped requests", xfer_start, 0);
  endtask

  task automatic t_recall();
    pulse_write_done();
    rd_req = 1'b1;
    rcl = 1'b1; tick(); rcl = 1'b0;
    chk("R9 recall start", xfer_start, 1);
    chk("R9 dir recall", xfer_dir, 0);
    chk("R11 no busy", line_pull, 0);
    chk("R9 read gated recall", rd_en, 0);
    wait_done();
    chk("R11 back to idle", rd_en, 1);
    rd_req = 1'b0; tick();
    t_hw_skip("after recall R11");
    sw = 1'b1; rcl = 1'b1; tick(); sw = 1'b0; rcl = 1'b0;
    chk("R10 sw over recall", xfer_dir, 1);
    chk("R10 start", xfer_start, 1);
    wait_done();
    tick();
    chk("R12 warn sticky", wear_warn, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_hw_skip("clean R1");
    t_hw_store();
    t_hw_skip("after store R1");
    t_sw_store();
    t_pwr();
    t_recall();
    summary();
    $finish;
  end

endmodule